// File: doc/BRIEF.md
# Three-Wire Configuration Port Slave

This block receives writes from a host microcontroller over a three-wire serial control bus made up of a bus clock, a serial data line and a mode line. All logic runs on the system clock. The three bus lines pass through a two-flop synchronizer and are then oversampled, so the bus clock is treated as data and the block needs no second clock domain. A byte sent while the mode line is low is an address byte. It carries a 6-bit device address and a 2-bit transfer type. Bytes sent while the mode line is high are data bytes. When the device is selected, each data byte writes one of the configuration fields: clock ratio, input format, volume code, de-emphasis or mute.

The address byte selects the register group and the top two bits of each data byte select the sub-register inside that group. The selection stays latched, so a host can write a long run of data bytes after one address byte. A static-pin fallback mode lets four board pins drive the mute, de-emphasis and format outputs directly. During that mode the bus still updates the stored registers.

Top module: `ctrl3w_slave`

## Requirements
- R1: A byte takes effect only after 8 data bits have been received. Every change of the mode line resets the bit count, so a partial byte is dropped and has no effect.
- R2: The block samples a data bit on each rising edge of the bus clock. Bits arrive LSB first, so the first bit sent is bit 0 of the byte.
- R3: An address byte (mode low) selects the device when its bits 7..2 equal 000101. Any other address deselects the device, and data bytes are then ignored until an address byte with the matching address arrives.
- R4: Bits 1..0 of the address byte set the transfer type: 00 is data, 10 is status. With type 01 or 11, data bytes change nothing.
- R5: The selected device and transfer type stay in force for any number of data bytes, until the next address byte.
- R6: A data-type byte with bits 7..6 = 00 loads bits 5..0 into the volume code.
- R7: A data-type byte with bits 7..6 = 10 loads de-emphasis from bits 4..3 (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and mute from bit 2 (1 = muted). A data-type byte with bits 7..6 = 01 or 11 changes nothing.
- R8: A status-type byte with bits 7..6 = 00 loads the clock ratio from bits 5..4 (00 512fs, 01 384fs, 10 256fs) and the input format from bits 3..1 (000 I2S, 001/010/011 LSB-justified 16/18/20 bits, 100 MSB-justified). A ratio code of 11 leaves the ratio unchanged, and a format code of 101 to 111 leaves the format unchanged. A status-type byte with any other value in bits 7..6 is ignored.
- R9: After reset the outputs are: volume 0, mute 0, de-emphasis 00, format 000 and clock ratio 10. The device is deselected and the transfer type is data.
- R10: While static_sel is high, mute equals pin_mute, de-emphasis is 10 when pin_deem is high and 00 otherwise, and the format is {0, pin_fmt1, pin_fmt0}. Volume and clock ratio still come from the stored registers.
- R11: When static_sel returns low, the outputs show the register values again, including any bus writes made while static mode was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock, asynchronous |
| bus_data | input | 1 | Serial bus data, LSB first |
| bus_mode | input | 1 | Low = address phase, high = data phase |
| static_sel | input | 1 | High selects static-pin mode |
| pin_mute | input | 1 | Static mute pin |
| pin_deem | input | 1 | Static de-emphasis pin (44.1 kHz) |
| pin_fmt0 | input | 1 | Static format select, low bit |
| pin_fmt1 | input | 1 | Static format select, high bit |
| clk_ratio | output | 2 | System clock ratio code |
| in_fmt | output | 3 | Input format code |
| volume | output | 6 | Volume attenuation code |
| deemph | output | 2 | De-emphasis code |
| mute | output | 1 | Mute enable |

## Verification
A bit counter that is out of phase would show up as rotated or misassembled values on volume, or as writes landing in the wrong sub-register. A stale select or transfer-type latch would show up as a field that changes after a foreign address or an unused type, or as a field that fails to change after a valid one. Each of these faults is visible on the output ports four system clocks after the eighth rising edge of the bus clock. The bench sweeps every volume code, every address, every status and data sub-field code and every static pin combination, so any such error lands in a field it compares.

// File: rtl/ctrl3w_pkg.sv
package ctrl3w_pkg;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned CNT_W     = $clog2(BYTE_BITS);
    localparam int unsigned LINES     = 3;   // {mode, data, clock}

    typedef enum logic [1:0] {
        XF_DATA   = 2'b00,
        XF_RSVD1  = 2'b01,
        XF_STATUS = 2'b10,
        XF_RSVD3  = 2'b11
    } xfer_e;

    typedef struct packed {
        logic [1:0] ratio;
        logic [2:0] fmt;
        logic [5:0] vol;
        logic [1:0] deem;
        logic       mute;
    } cfg_t;

    localparam logic [1:0] RATIO_RESET = 2'b10;
    localparam logic [2:0] FMT_LAST    = 3'b100;
    localparam logic [1:0] DEEM_STATIC = 2'b10;

endpackage

// File: rtl/ctrl3w_sync.sv
module ctrl3w_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/ctrl3w_shift.sv
module ctrl3w_shift
    import ctrl3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_s,
    input  logic                 data_s,
    input  logic                 mode_s,
    output logic                 done_o,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 byte_mode_o
);

    typedef struct packed {
        logic                 clk_prev;
        logic                 mode_prev;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] sr;
        logic                 done;
        logic [BYTE_BITS-1:0] byte_v;
        logic                 byte_mode;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      clk_rise;
    logic      mode_chg;

    assign clk_rise = clk_s & ~st_q.clk_prev;
    assign mode_chg = mode_s ^ st_q.mode_prev;

    always_comb begin
        st_d           = st_q;
        st_d.clk_prev  = clk_s;
        st_d.mode_prev = mode_s;
        st_d.done      = 1'b0;
        if (mode_chg) begin
            st_d.cnt = '0;
        end else if (clk_rise) begin
            st_d.sr  = {data_s, st_q.sr[BYTE_BITS-1:1]};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(BYTE_BITS - 1)) begin
                st_d.done      = 1'b1;
                st_d.byte_v    = {data_s, st_q.sr[BYTE_BITS-1:1]};
                st_d.byte_mode = mode_s;
                st_d.cnt       = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o      = st_q.done;
    assign byte_o      = st_q.byte_v;
    assign byte_mode_o = st_q.byte_mode;

    // R1: a finished byte always follows a sampled bus-clock rise
    p_done_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(clk_rise));

    // R1: any mode-line change restarts the bit count
    p_mode_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.cnt == '0 && !st_q.done));

endmodule

// File: rtl/ctrl3w_regs.sv
module ctrl3w_regs
    import ctrl3w_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR = 6'b000101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic [BYTE_BITS-1:0] byte_i,
    input  logic                 byte_mode_i,
    output cfg_t                 cfg_o
);

    typedef struct packed {
        logic  sel;
        xfer_e xtype;
        cfg_t  cfg;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            if (!byte_mode_i) begin
                st_d.sel   = (byte_i[7:2] == DEV_ADDR);
                st_d.xtype = xfer_e'(byte_i[1:0]);
            end else if (st_q.sel) begin
                unique case (st_q.xtype)
                    XF_DATA: begin
                        unique case (byte_i[7:6])
                            2'b00: st_d.cfg.vol = byte_i[5:0];
                            2'b10: begin
                                st_d.cfg.deem = byte_i[4:3];
                                st_d.cfg.mute = byte_i[2];
                            end
                            default: ;
                        endcase
                    end
                    XF_STATUS: begin
                        if (byte_i[7:6] == 2'b00) begin
                            if (byte_i[5:4] != 2'b11)  st_d.cfg.ratio = byte_i[5:4];
                            if (byte_i[3:1] <= FMT_LAST) st_d.cfg.fmt = byte_i[3:1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.xtype     <= XF_DATA;
            st_q.cfg.ratio <= RATIO_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    // R1: configuration moves only right after a completed byte
    p_cfg_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cfg) |-> $past(done_i && byte_mode_i));

    // R3: a deselected device never changes its configuration
    p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cfg) |-> $past(st_q.sel));

    // R8: unused ratio and format codes never reach the registers
    p_ratio_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.ratio != 2'b11);
    p_fmt_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.fmt <= FMT_LAST);

endmodule

// File: rtl/ctrl3w_slave.sv
module ctrl3w_slave
    import ctrl3w_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [5:0]  DEV_ADDR    = 6'b000101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clk,
    input  logic       bus_data,
    input  logic       bus_mode,
    input  logic       static_sel,
    input  logic       pin_mute,
    input  logic       pin_deem,
    input  logic       pin_fmt0,
    input  logic       pin_fmt1,
    output logic [1:0] clk_ratio,
    output logic [2:0] in_fmt,
    output logic [5:0] volume,
    output logic [1:0] deemph,
    output logic       mute
);

    logic [LINES-1:0]     lines_s;
    logic                 done;
    logic [BYTE_BITS-1:0] byte_v;
    logic                 byte_mode;
    cfg_t                 cfg;

    ctrl3w_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_mode, bus_data, bus_clk}),
        .sync_o  (lines_s)
    );

    ctrl3w_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_s       (lines_s[0]),
        .data_s      (lines_s[1]),
        .mode_s      (lines_s[2]),
        .done_o      (done),
        .byte_o      (byte_v),
        .byte_mode_o (byte_mode)
    );

    ctrl3w_regs #(.DEV_ADDR(DEV_ADDR)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done),
        .byte_i      (byte_v),
        .byte_mode_i (byte_mode),
        .cfg_o       (cfg)
    );

    always_comb begin
        clk_ratio = cfg.ratio;
        volume    = cfg.vol;
        if (static_sel) begin
            mute   = pin_mute;
            deemph = pin_deem ? DEEM_STATIC : 2'b00;
            in_fmt = {1'b0, pin_fmt1, pin_fmt0};
        end else begin
            mute   = cfg.mute;
            deemph = cfg.deem;
            in_fmt = cfg.fmt;
        end
    end

endmodule

// File: tb/sim_ctrl3w_slave.sv
module sim_ctrl3w_slave;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_mode = 1'b0;
    logic static_sel = 1'b0;
    logic pin_mute = 1'b0, pin_deem = 1'b0, pin_fmt0 = 1'b0, pin_fmt1 = 1'b0;
    logic [1:0] clk_ratio;
    logic [2:0] in_fmt;
    logic [5:0] volume;
    logic [1:0] deemph;
    logic       mute;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int e_vol = 0, e_deem = 0, e_mute = 0, e_fmt = 0, e_ratio = 2;

    always #4 clk = ~clk;   // 125 MHz

    ctrl3w_slave u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_clk(bus_clk), .bus_data(bus_data), .bus_mode(bus_mode),
        .static_sel(static_sel), .pin_mute(pin_mute), .pin_deem(pin_deem),
        .pin_fmt0(pin_fmt0), .pin_fmt1(pin_fmt1),
        .clk_ratio(clk_ratio), .in_fmt(in_fmt), .volume(volume),
        .deemph(deemph), .mute(mute)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " volume"}, int'(volume), e_vol);
        chk({tag, " deemph"}, int'(deemph), e_deem);
        chk({tag, " mute"}, int'(mute), e_mute);
        chk({tag, " in_fmt"}, int'(in_fmt), e_fmt);
        chk({tag, " clk_ratio"}, int'(clk_ratio), e_ratio);
    endtask

    task automatic set_mode(input logic m);
        bus_mode = m;
        tick(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            bus_data = b[i];
            tick(3);
            bus_clk = 1'b1;
            tick(3);
            bus_clk = 1'b0;
        end
        tick(6);
    endtask

    task automatic send_addr(input logic [5:0] a, input logic [1:0] t);
        set_mode(1'b0);
        send_bits({a, t}, 8);
        set_mode(1'b1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk_all("R9 reset");

        // R6 R5: one address, exhaustive volume sweep
        send_addr(6'b000101, 2'b00);
        for (int v = 0; v < 64; v++) begin
            send_bits({2'b00, 6'(63 - v)}, 8);
            e_vol = 63 - v;
            chk("R6 R5 volume sweep", int'(volume), e_vol);
        end

        // R2: LSB-first bit order on a non-symmetric value
        send_bits(8'b0000_0110, 8);
        e_vol = 6;
        chk_all("R2 bit order");

        // R7: de-emphasis / mute sweep
        for (int k = 0; k < 8; k++) begin
            send_bits({2'b10, 1'b0, 2'(k >> 1), 1'(k), 2'b00}, 8);
            e_deem = k >> 1;
            e_mute = k & 1;
            chk_all("R7 deem/mute");
        end
        // R7: sub-registers 01 and 11 ignored
        send_bits(8'b0111_1111, 8);
        send_bits(8'b1100_0000, 8);
        chk_all("R7 unused subaddress");

        // R1: partial byte dropped, count restarts
        send_bits(8'b0011_1111, 5);
        chk_all("R1 partial");
        set_mode(1'b0);
        set_mode(1'b1);
        send_bits(8'b0001_0101, 8);
        e_vol = 21;
        chk_all("R1 after restart");

        // R4: unused transfer types
        send_addr(6'b000101, 2'b01);
        send_bits(8'b0010_1010, 8);
        chk_all("R4 type 01");
        send_addr(6'b000101, 2'b11);
        send_bits(8'b0010_1010, 8);
        send_bits(8'b0000_0100, 8);
        chk_all("R4 type 11");

        // R8: status type, ratio sweep then format sweep
        send_addr(6'b000101, 2'b10);
        for (int r = 0; r < 4; r++) begin
            send_bits({2'b00, 2'(r), 3'b000, 1'b0}, 8);
            if (r != 3) e_ratio = r;
            e_fmt = 0;
            chk_all("R8 ratio");
        end
        for (int f = 0; f < 8; f++) begin
            send_bits({2'b00, 2'b01, 3'(f), 1'b1}, 8);
            e_ratio = 1;
            if (f <= 4) e_fmt = f;
            chk_all("R8 format");
        end
        send_bits(8'b0100_0000, 8);
        send_bits(8'b1000_0000, 8);
        chk_all("R8 status top bits");

        // R3: address sweep, volume write after each address
        e_vol = 0;
        send_addr(6'b000101, 2'b00);
        send_bits(8'h00, 8);
        for (int a = 0; a < 64; a++) begin
            send_addr(6'(a), 2'b00);
            send_bits({2'b00, 6'(a ^ 6'h2A)}, 8);
            if (a == 5) e_vol = a ^ 6'h2A;
            chk("R3 address sweep", int'(volume), e_vol);
        end

        // R10: static-pin mode, all pin combinations
        static_sel = 1'b1;
        for (int p = 0; p < 16; p++) begin
            {pin_fmt1, pin_fmt0, pin_deem, pin_mute} = 4'(p);
            tick(2);
            chk("R10 static mute", int'(mute), p & 1);
            chk("R10 static deemph", int'(deemph), ((p >> 1) & 1) * 2);
            chk("R10 static fmt", int'(in_fmt), p >> 2);
            chk("R10 static volume", int'(volume), e_vol);
            chk("R10 static ratio", int'(clk_ratio), e_ratio);
        end
        // R11: bus writes during static mode show when leaving it
        send_addr(6'b000101, 2'b00);
        send_bits(8'b1001_0100, 8);
        e_deem = 2;
        e_mute = 1;
        static_sel = 1'b0;
        tick(2);
        chk_all("R11 leave static");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule